// File: doc/BRIEF.md
# Population count and leading-zero unit

This unit counts bits in an XLEN-wide operand. Each cycle it can accept one operand together with an operation select. It returns either the number of set bits (population count) or find-first, which is the number of zero bits above the highest set bit, counted downward from the MSB. Both counts are formed by log-depth trees, so logic depth grows with log2(XLEN) and not with XLEN.

An all-zero operand has no set bit, and two conventions exist for what find-first should return in that case. The `zero_neg` input picks one of them: XLEN (the scalar convention) or all ones, which is -1 as a signed value (the vector-mask convention). The result is a signed XLEN-wide word.

The `LATENCY` parameter sets the number of register stages after the count logic. `out_valid` follows `in_valid` through the same number of stages. `LATENCY` = 0 gives a purely combinational path.

Top module: `bitcount_unit`

## Requirements
- R1: With `op_sel` = 0, `result` is the number of 1 bits in `operand`, zero-extended to XLEN bits.
- R2: Population count returns 0 for an all-zero operand and XLEN for an all-ones operand.
- R3: With `op_sel` = 1 and a nonzero operand, `result` is the count of zero bits above the highest set bit. An operand with bit XLEN-1 set gives 0.
- R4: With `op_sel` = 1, an all-zero operand and `zero_neg` = 0, `result` is XLEN.
- R5: With `op_sel` = 1, an all-zero operand and `zero_neg` = 1, every bit of `result` is 1 (value -1).
- R6: With `op_sel` = 0, `zero_neg` has no effect on `result`.
- R7: `out_valid` is high exactly LATENCY cycles after a cycle with `in_valid` high, and `result` carries that operand's answer in the same cycle. With the default LATENCY of 1, this is the next cycle.
- R8: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| op_sel | input | 1 | 0 selects population count, 1 selects find-first |
| zero_neg | input | 1 | Find-first on a zero operand: 0 returns XLEN, 1 returns -1 |
| operand | input | XLEN | Value to count |
| out_valid | output | 1 | `result` holds a finished count |
| result | output | XLEN | Signed count |

## Verification
With the default LATENCY of 1, every answer is due in the clock cycle after the rising edge that captures its operand. The driver applies each operand on a falling edge and queues the expected word computed by its own bit loops. The monitor samples shortly after each rising edge. At that point it expects `out_valid` high and a matching result exactly when one item is waiting in the queue, and `out_valid` low otherwise. This covers single operands, back-to-back operands and gaps between operands.

// File: rtl/bitcount_unit.sv
module bitcount_unit #(
  parameter int XLEN    = 32,
  parameter int LATENCY = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   op_sel,
  input  logic                   zero_neg,
  input  logic [XLEN-1:0]        operand,
  output logic                   out_valid,
  output logic signed [XLEN-1:0] result
);
  localparam int LV    = $clog2(XLEN);
  localparam int CW    = LV + 1;
  localparam int NODES = 2 * XLEN - 1;

  // Heap-ordered trees: node n has children 2n+1 (upper half) and 2n+2.
  logic [CW-1:0] pc [NODES];
  logic [CW-1:0] lz [NODES];
  logic          az [NODES];
  logic [XLEN-1:0] res_d;

  for (genvar j = 0; j < XLEN; j++) begin : g_leaf
    assign pc[XLEN-1+j] = {{LV{1'b0}}, operand[XLEN-1-j]};
    assign lz[XLEN-1+j] = {{LV{1'b0}}, ~operand[XLEN-1-j]};
    assign az[XLEN-1+j] = ~operand[XLEN-1-j];
  end

  for (genvar n = 0; n < XLEN - 1; n++) begin : g_node
    assign pc[n] = pc[2*n+1] + pc[2*n+2];
    assign az[n] = az[2*n+1] & az[2*n+2];
    assign lz[n] = az[2*n+1] ? lz[2*n+1] + lz[2*n+2] : lz[2*n+1];
  end

  always_comb begin
    if (!op_sel)
      res_d = XLEN'(pc[0]);
    else if (az[0] && zero_neg)
      res_d = '1;
    else
      res_d = XLEN'(lz[0]);
  end

  if (LATENCY == 0) begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_d;
  end else begin : g_pipe
    logic            vq [LATENCY];
    logic [XLEN-1:0] rq [LATENCY];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < LATENCY; k++) vq[k] <= 1'b0;
      end else begin
        vq[0] <= in_valid;
        for (int k = 1; k < LATENCY; k++) vq[k] <= vq[k-1];
      end
      rq[0] <= res_d;
      for (int k = 1; k < LATENCY; k++) rq[k] <= rq[k-1];
    end

    assign out_valid = vq[LATENCY-1];
    assign result    = rq[LATENCY-1];

    if (LATENCY == 1) begin : g_lat1_chk
      p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    end
  end

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid || (LATENCY == 0)));
  p_pop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel && (&operand)) |-> (res_d == XLEN'(XLEN)));
  p_msb_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && operand[XLEN-1]) |-> (res_d == '0));
  p_zero_scalar_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && operand == '0 && !zero_neg) |-> (res_d == XLEN'(XLEN)));
  p_zero_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && operand == '0 && zero_neg) |-> (&res_d));
  p_pop_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel) |-> (res_d <= XLEN'(XLEN)));
endmodule

// File: tb/bitcount_unit_test.sv
module bitcount_unit_test;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic op_sel = 1'b0;
  logic zero_neg = 1'b0;
  logic [XLEN-1:0] operand = '0;
  logic out_valid;
  logic signed [XLEN-1:0] result;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [XLEN-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bitcount_unit #(.XLEN(XLEN), .LATENCY(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .zero_neg(zero_neg), .operand(operand), .out_valid(out_valid), .result(result)
  );

  function automatic logic [XLEN-1:0] ref_model(input logic op, input logic zn,
                                                input logic [XLEN-1:0] v);
    int c = 0;
    if (!op) begin
      for (int b = 0; b < XLEN; b++) if (v[b]) c++;
      return XLEN'(c);
    end
    if (v == '0) return zn ? '1 : XLEN'(XLEN);
    for (int b = XLEN - 1; b >= 0; b--) begin
      if (v[b]) return XLEN'(c);
      c++;
    end
    return XLEN'(c);
  endfunction

  task automatic send(input logic op, input logic zn, input logic [XLEN-1:0] v,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; zero_neg = zn; operand = v;
    exp_q.push_back(ref_model(op, zn, v));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; operand = $urandom; op_sel = $urandom; zero_neg = $urandom;
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      checks++;
      if (exp_q.size() > 0) begin
        logic [XLEN-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (!out_valid) begin
          errors++;
          $display("FAIL R7 out_valid missing for %s: actual %0b expected 1", t, out_valid);
        end else if (result !== e) begin
          errors++;
          $display("FAIL %s result: actual %h expected %h", t, result, e);
        end
      end else if (out_valid) begin
        errors++;
        $display("FAIL R7 unexpected out_valid: actual 1 expected 0");
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    finish_run();
  end

  initial begin
    in_valid = 1'b1;
    operand = 32'hFFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R8 out_valid in reset: actual %0b expected 0", out_valid);
      end
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8 out_valid after reset: actual %0b expected 0", out_valid);
    end

    send(1'b0, 1'b0, 32'h0000_0000, "R2 pop zero");
    send(1'b0, 1'b0, 32'hFFFF_FFFF, "R2 pop ones");
    send(1'b0, 1'b0, 32'hF0F0_0001, "R1 pop pattern");
    send(1'b0, 1'b0, 32'h8000_0000, "R1 pop msb");
    idle(2);
    send(1'b1, 1'b0, 32'h8000_0000, "R3 ff msb");
    send(1'b1, 1'b1, 32'hFFFF_FFFF, "R3 ff ones");
    send(1'b1, 1'b0, 32'h0000_0001, "R3 ff lsb");
    send(1'b1, 1'b0, 32'h0001_0000, "R3 ff mid");
    send(1'b1, 1'b1, 32'h0000_0300, "R3 ff zneg nonzero");
    idle(1);
    send(1'b1, 1'b0, 32'h0000_0000, "R4 ff zero scalar");
    idle(1);
    send(1'b1, 1'b1, 32'h0000_0000, "R5 ff zero neg");
    send(1'b0, 1'b1, 32'h0000_0000, "R6 pop zero zneg");
    send(1'b0, 1'b1, 32'h0000_0007, "R6 pop seven zneg");
    send(1'b0, 1'b1, 32'hFFFF_FFFF, "R6 pop ones zneg");
    idle(3);
    for (int i = 0; i < 60; i++) begin
      logic [XLEN-1:0] v;
      v = $urandom;
      if (i % 3 == 1) v = v >> (i % 32);
      send(1'(i % 2), 1'($urandom), v, (i % 2) ? "R3 ff random" : "R1 pop random");
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 results outstanding: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule